// File: doc/BRIEF.md
# DRAM Start-up and Refresh Scheduler

This block sits beside a DRAM access controller. It holds off all memory activity after reset for a configurable start-up pause. It then requests a short burst of dummy row-strobe wake-up cycles. After that it raises a refresh request at a fixed interval, and each refresh carries the next row address from a wrapping row counter.

The access controller serves a request by pulsing the acknowledge input in a cycle where the request is high. A small counter records refreshes that have fallen due but have not yet been acknowledged. If the controller is busy for a few intervals, those refreshes are still owed and are served back to back once it catches up.

The `initDone` output tells the host path when normal traffic may start. The default parameters assume a 100 MHz clock: a 50,000-cycle pause, eight wake-up cycles, and a 1560-cycle interval. With that interval, 128 refreshes take 199,680 cycles, which is just inside a 2 ms retention period.

Top module: `refresh_sched`

## Requirements
- R1: For the first PAUSE_CYCLES rising clock edges after reset is released, `refReq` and `initDone` stay low and `pendCount` stays 0. After reset, `refAddr` is 0.
- R2: After edge PAUSE_CYCLES, `refReq` is held high until WAKE_COUNT acknowledges have been accepted. `initDone` goes high in the cycle after the edge that accepts the last of them, and it then stays high until reset.
- R3: `refAddr[ROW_BITS-1:0]` is a row counter that rises by one on every accepted acknowledge, for wake-up cycles and refreshes alike. It wraps from 2^ROW_BITS-1 to 0. The bits of `refAddr` above ROW_BITS-1 are always 0.
- R4: An acknowledge is accepted only in a cycle where `refReq` is high. An acknowledge at any other time leaves `refAddr` and `pendCount` unchanged.
- R5: Once `initDone` is high, one refresh falls due every INTERVAL cycles. The first one falls due INTERVAL edges after the edge that raised `initDone`.
- R6: When a refresh falls due, `pendCount` rises by one, saturating at OWED_MAX. An accepted acknowledge lowers it by one. When both happen at the same edge, it is unchanged. While `initDone` is high, `refReq` is high exactly when `pendCount` is non-zero.
- R7: If every request is acknowledged at once, any run of 2^ROW_BITS × INTERVAL cycles after `initDone` contains at least 2^ROW_BITS accepted acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refAck | input | 1 | Acknowledge from the access controller; accepted only when `refReq` is high |
| refReq | output | 1 | Wake-up or refresh row-strobe cycle requested |
| refAddr | output | ADDR_BITS | Row address for the requested cycle |
| initDone | output | 1 | Start-up sequence finished; host traffic may proceed |
| pendCount | output | $clog2(OWED_MAX+1) | Number of refreshes owed and not yet acknowledged |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released. They also assume that `refAck` is a clean synchronous level, so it can be high when no request is pending. The bench drives the acknowledge only at falling edges, either as a direct echo of the request or as a stray pulse. It uses a small configuration in which row wrap-around, saturation of the owed count and a full retention window all occur within a few hundred cycles.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } schedState_t;

  typedef struct packed {
    logic rowStep;
    logic owedInc;
    logic owedDec;
  } schedStrobe_t;

endpackage

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int PAUSE_CYCLES = 50000,
  parameter int WAKE_COUNT   = 8,
  parameter int INTERVAL     = 1560
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refAck,
  input  logic         owedNz,
  output logic         refReq,
  output logic         initDone,
  output schedStrobe_t strobe
);

  localparam int PW = $clog2(PAUSE_CYCLES + 1);
  localparam int WW = $clog2(WAKE_COUNT + 1);
  localparam int IW = $clog2(INTERVAL + 1);
  localparam logic [PW-1:0] PLAST = PW'(PAUSE_CYCLES - 1);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_COUNT - 1);
  localparam logic [IW-1:0] ILAST = IW'(INTERVAL - 1);

  schedState_t   st;
  logic [PW-1:0] pauseCnt;
  logic [WW-1:0] wakeCnt;
  logic [IW-1:0] ivCnt;
  logic          ackOk;
  logic          tick;

  always_comb begin
    refReq   = (st == ST_WAKE) || ((st == ST_RUN) && owedNz);
    ackOk    = refAck && refReq;
    tick     = (st == ST_RUN) && (ivCnt == ILAST);
    initDone = (st == ST_RUN);
    strobe.rowStep = ackOk;
    strobe.owedInc = tick;
    strobe.owedDec = ackOk && (st == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_PAUSE;
      pauseCnt <= '0;
      wakeCnt  <= '0;
      ivCnt    <= '0;
    end else begin
      unique case (st)
        ST_PAUSE: begin
          if (pauseCnt == PLAST) st <= ST_WAKE;
          else                   pauseCnt <= pauseCnt + 1'b1;
        end
        ST_WAKE: begin
          if (ackOk) begin
            if (wakeCnt == WLAST) st <= ST_RUN;
            else                  wakeCnt <= wakeCnt + 1'b1;
          end
        end
        ST_RUN: begin
          ivCnt <= tick ? '0 : ivCnt + 1'b1;
        end
        default: st <= ST_PAUSE;
      endcase
    end
  end

endmodule

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int ROW_BITS  = 7,
  parameter int ADDR_BITS = 8,
  parameter int OWED_MAX  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  schedStrobe_t                    strobe,
  output logic                            owedNz,
  output logic [ADDR_BITS-1:0]            refAddr,
  output logic [$clog2(OWED_MAX+1)-1:0]   pendCount
);

  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [OW-1:0] OMAX = OW'(OWED_MAX);

  logic [ROW_BITS-1:0] rowCnt;
  logic [OW-1:0]       owed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowCnt <= '0;
      owed   <= '0;
    end else begin
      if (strobe.rowStep) rowCnt <= rowCnt + 1'b1;
      unique case ({strobe.owedInc, strobe.owedDec})
        2'b10:   if (owed != OMAX) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign owedNz    = (owed != '0);
  assign pendCount = owed;

  generate
    if (ADDR_BITS > ROW_BITS) begin : g_pad
      assign refAddr = {{(ADDR_BITS - ROW_BITS){1'b0}}, rowCnt};
    end else begin : g_flat
      assign refAddr = rowCnt;
    end
  endgenerate

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int PAUSE_CYCLES = 50000,
  parameter int WAKE_COUNT   = 8,
  parameter int INTERVAL     = 1560,
  parameter int ROW_BITS     = 7,
  parameter int ADDR_BITS    = 8,
  parameter int OWED_MAX     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refAck,
  output logic                          refReq,
  output logic [ADDR_BITS-1:0]          refAddr,
  output logic                          initDone,
  output logic [$clog2(OWED_MAX+1)-1:0] pendCount
);

  schedStrobe_t strobe;
  logic         owedNz;

  refresh_sched_ctrl #(
    .PAUSE_CYCLES(PAUSE_CYCLES),
    .WAKE_COUNT  (WAKE_COUNT),
    .INTERVAL    (INTERVAL)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .refAck  (refAck),
    .owedNz  (owedNz),
    .refReq  (refReq),
    .initDone(initDone),
    .strobe  (strobe)
  );

  refresh_sched_dp #(
    .ROW_BITS (ROW_BITS),
    .ADDR_BITS(ADDR_BITS),
    .OWED_MAX (OWED_MAX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .owedNz   (owedNz),
    .refAddr  (refAddr),
    .pendCount(pendCount)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int PAUSE_CYCLES = 50000,
  parameter int WAKE_COUNT   = 8,
  parameter int ROW_BITS     = 7,
  parameter int ADDR_BITS    = 8,
  parameter int OWED_MAX     = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          refAck,
  input logic                          refReq,
  input logic [ADDR_BITS-1:0]          refAddr,
  input logic                          initDone,
  input logic [$clog2(OWED_MAX+1)-1:0] pendCount
);

  localparam int CW = $clog2(PAUSE_CYCLES + 1);
  localparam int WW = $clog2(WAKE_COUNT + 1) + 1;

  logic [CW-1:0]       sinceRst;
  logic [WW-1:0]       wakeAcks;
  logic [ROW_BITS-1:0] rowNow;
  logic                accepted;

  assign rowNow   = refAddr[ROW_BITS-1:0];
  assign accepted = refAck && refReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= '0;
      wakeAcks <= '0;
    end else begin
      if (sinceRst != CW'(PAUSE_CYCLES)) sinceRst <= sinceRst + 1'b1;
      if (!initDone && accepted) wakeAcks <= wakeAcks + 1'b1;
    end
  end

  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < CW'(PAUSE_CYCLES)) |-> (!refReq && !initDone));

  p_wake_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (wakeAcks == WW'(WAKE_COUNT)));

  p_init_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (rowNow == ROW_BITS'($past(rowNow) + 1'b1)));

  p_row_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(refAddr));

  p_req_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (refReq == (pendCount != '0)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= ($clog2(OWED_MAX+1))'(OWED_MAX));

  generate
    if (ADDR_BITS > ROW_BITS) begin : g_top
      p_top_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
        refAddr[ADDR_BITS-1:ROW_BITS] == '0);
    end
  endgenerate

endmodule

bind refresh_sched refresh_sched_chk #(
  .PAUSE_CYCLES(PAUSE_CYCLES),
  .WAKE_COUNT  (WAKE_COUNT),
  .ROW_BITS    (ROW_BITS),
  .ADDR_BITS   (ADDR_BITS),
  .OWED_MAX    (OWED_MAX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refAck   (refAck),
  .refReq   (refReq),
  .refAddr  (refAddr),
  .initDone (initDone),
  .pendCount(pendCount)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;

  localparam int PAUSE = 40;
  localparam int WAKE  = 8;
  localparam int IVL   = 20;
  localparam int ROWB  = 4;
  localparam int ADRB  = 5;
  localparam int OMAX  = 4;
  localparam int ROWS  = 1 << ROWB;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            autoAck = 1'b0;
  logic            strayAck = 1'b0;
  logic            refAck;
  logic            refReq;
  logic [ADRB-1:0] refAddr;
  logic            initDone;
  logic [2:0]      pendCount;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ackTotal = 0;
  int wraps = 0;
  logic [ROWB-1:0] expRow = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign refAck = (autoAck && refReq) || strayAck;

  refresh_sched #(
    .PAUSE_CYCLES(PAUSE), .WAKE_COUNT(WAKE), .INTERVAL(IVL),
    .ROW_BITS(ROWB), .ADDR_BITS(ADRB), .OWED_MAX(OMAX)
  ) u_dut (
    .clk(clk), .rstN(rstN), .refAck(refAck), .refReq(refReq),
    .refAddr(refAddr), .initDone(initDone), .pendCount(pendCount)
  );

  // Independent model of the row counter and acknowledge tally
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      expRow <= '0;
    end else if (refAck && refReq) begin
      expRow   <= expRow + 1'b1;
      ackTotal <= ackTotal + 1;
      if (expRow == ROWB'(ROWS - 1)) wraps <= wraps + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    int n;
    int a0;
    bit quiet;
    autoAck = 1'b1;
    repeat (3) @(negedge clk);
    check(!refReq && !initDone && pendCount == 0 && refAddr == 0, "R1 reset state",
          {refReq, initDone, pendCount, refAddr}, 0);
    rstN = 1'b1;

    quiet = 1'b1;
    for (int k = 1; k < PAUSE; k++) begin
      @(negedge clk);
      if (refReq || initDone || pendCount != 0) quiet = 1'b0;
    end
    check(quiet, "R1 quiet during pause", quiet, 1);
    @(negedge clk);
    check(refReq && !initDone, "R2 wake request after pause", {refReq, initDone}, 2);
    check(refAddr == 0, "R3 first wake address", refAddr, 0);

    repeat (WAKE - 1) @(negedge clk);
    check(!initDone, "R2 not done before last wake ack", initDone, 0);
    @(negedge clk);
    check(initDone && !refReq, "R2 done after eighth ack", {initDone, refReq}, 2);
    check(refAddr == ADRB'(WAKE), "R3 row advanced by wake cycles", refAddr, WAKE);

    n = 0;
    while (!refReq && n < 100) begin @(negedge clk); n++; end
    check(n == IVL, "R5 first refresh due", n, IVL);
    @(negedge clk);
    check(!refReq && refAddr == ADRB'(WAKE + 1), "R3 refresh advances row", refAddr, WAKE + 1);
    n = 0;
    while (!refReq && n < 100) begin @(negedge clk); n++; end
    check(n == IVL - 1, "R5 refresh spacing", n, IVL - 1);
    @(negedge clk);
    autoAck = 1'b0;

    repeat (3 * IVL) @(negedge clk);
    check(pendCount == 3 && refReq, "R6 owed count accumulates", pendCount, 3);
    check(refAddr == ADRB'(WAKE + 2), "R4 row holds while unacknowledged", refAddr, WAKE + 2);
    repeat (3 * IVL) @(negedge clk);
    check(pendCount == OMAX, "R6 owed count saturates", pendCount, OMAX);

    autoAck = 1'b1;
    repeat (OMAX) @(negedge clk);
    check(pendCount == 0 && !refReq, "R6 owed refreshes drained", pendCount, 0);
    check(refAddr == ADRB'(WAKE + 2 + OMAX), "R3 back-to-back rows", refAddr, WAKE + 2 + OMAX);

    autoAck = 1'b0;
    strayAck = 1'b1;
    repeat (5) @(negedge clk);
    check(refAddr == ADRB'(WAKE + 2 + OMAX) && pendCount == 0, "R4 stray ack ignored",
          refAddr, WAKE + 2 + OMAX);
    strayAck = 1'b0;
    autoAck = 1'b1;

    a0 = ackTotal;
    repeat (ROWS * IVL) @(negedge clk);
    check(ackTotal - a0 >= ROWS, "R7 retention window coverage", ackTotal - a0, ROWS);
    check(refAddr == {1'b0, expRow}, "R3 address after wrap", refAddr, int'(expRow));
    check(wraps >= 1, "R3 row wrapped", wraps, 1);
    check(initDone, "R2 done stays high", initDone, 1);

    finishRun();
  end

endmodule